// File: doc/BRIEF.md
# Two-Bank Clock Source Switch Sequencer

This block owns the control state of a glitch-free clock source selector that has two settings banks. Each bank is one byte holding a source-select field and a divider field. A select bit decides which bank currently drives the mux output. A request to move onto the muxed path never touches the live bank. The block writes the new source and divider into the idle bank and then inverts the select bit, so the mux only ever switches between two stable settings.

A two-bit core-source field, held next to the select bit, chooses among four paths: the muxed path, the tunable PLL, the bus clock, or a fixed low-jitter PLL that also passes through the mux. A PLL request writes a 6-bit multiplier value into the PLL frequency-control word before the core source is changed. The block also decodes its own state into the running source, divider and multiplier on a registered readback port. A core-source value of 3 raises an illegal flag when the build marks the low-jitter path as unsupported.

Top module: `clksrc_pingpong`

## Requirements
- R1: While `rst` is high, `ctl_word`, `sel_word` and `pll_word` take the reset parameters, and `busy` and `done` are 0.
- R2: A request with `req_core`=0 writes bank index `sel_word[0]` of `ctl_word` (bank n is bits [8n+7:8n], with the source in bits [8n+6:8n+4], 0 in bit 8n+7, and the divider in bits [8n+3:8n]). The other, active bank is not changed.
- R3: For a `req_core`=0 request accepted at edge E0, the bank is written at E1, `sel_word[0]` is inverted at E2, `sel_word[2:1]` is written at E3, and `done` is high for the single cycle after E3.
- R4: `sel_word[2:1]` holds the core source (0 mux, 1 tunable PLL, 2 bus clock, 3 low-jitter PLL through the mux). Writing it leaves `sel_word[0]` and `sel_word[7:3]` unchanged.
- R5: A request with `req_core` other than 0 leaves `ctl_word` and `sel_word[0]` unchanged.
- R6: A request with `req_core`=1 writes `req_lval` into `pll_word[8:3]` one edge after acceptance and keeps the other PLL bits. The core source is written on the following edge, and `done` follows it. No other request writes `pll_word`.
- R7: One cycle after the state changes, with core source 0 or 3, the readback gives source `ctl_word[6:4]` and divider `ctl_word[3:0]` when `sel_word[0]`=1. When `sel_word[0]`=0 it gives `ctl_word[14:12]` and `ctl_word[11:8]`. `rd_lval` is 0 in both cases.
- R8: With core source 1, `rd_lval` is `pll_word[8:3]`, and `rd_src` and `rd_div` are 0.
- R9: With core source 2, `rd_src`, `rd_div` and `rd_lval` are all 0.
- R10: With core source 3 and the low-jitter path marked unsupported, `rd_illegal` is 1. For every other core source it is 0.
- R11: `req_valid` is ignored while `busy` is 1. Only the accepted request affects the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Switch request strobe |
| req_core | input | 2 | Target core source |
| req_src | input | SRC_W | Target mux source select |
| req_div | input | DIV_W | Target mux divider |
| req_lval | input | LVAL_W | Target PLL multiplier |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| ctl_word | output | 4*FIELD_W | Two-bank control word |
| sel_word | output | SEL_W | Bank select bit and core source |
| pll_word | output | PLL_W | PLL frequency-control word |
| rd_core | output | 2 | Decoded core source |
| rd_src | output | SRC_W | Decoded source select |
| rd_div | output | DIV_W | Decoded divider |
| rd_lval | output | LVAL_W | Decoded PLL multiplier |
| rd_illegal | output | 1 | Unsupported core source decoded |

## Verification
The bench builds the block with the default field widths, with the low-jitter path marked unsupported, and with nonzero reset words: select bit 1, upper selection bits 10100, and scattered PLL bits. These reset words make the first mux request land in bank 1 and show whether the upper selection bits survive each write. They also show whether the PLL bits outside the multiplier field survive a PLL request. The run alternates banks in both directions and visits every core source. The unsupported setting brings the illegal flag within reach on core source 3.

// File: rtl/clksrc_pp_pkg.sv
package clksrc_pp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BANK,
    ST_FLIP,
    ST_PLL,
    ST_CORE
  } seq_t;

  localparam logic [1:0] CORE_MUX = 2'd0;
  localparam logic [1:0] CORE_PLL = 2'd1;
  localparam logic [1:0] CORE_BUS = 2'd2;
  localparam logic [1:0] CORE_LJ  = 2'd3;
endpackage

// File: rtl/clksrc_pp_bankwr.sv
module clksrc_pp_bankwr #(
  parameter int FIELD_W = 4,
  parameter int SRC_W   = 3,
  parameter int DIV_W   = 4,
  parameter int NBANK   = 2,
  localparam int BANK_W = 2 * FIELD_W,
  localparam int CTL_W  = NBANK * BANK_W
) (
  input  logic [CTL_W-1:0] ctl_i,
  input  logic             bank_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [CTL_W-1:0] ctl_o
);
  logic [BANK_W-1:0] fresh;

  always_comb begin
    fresh = '0;
    fresh[FIELD_W +: SRC_W] = src_i;
    fresh[0 +: DIV_W]       = div_i;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign ctl_o[b*BANK_W +: BANK_W] =
      (int'(bank_i) == b) ? fresh : ctl_i[b*BANK_W +: BANK_W];
  end
endmodule

// File: rtl/clksrc_pp_selupd.sv
module clksrc_pp_selupd #(
  parameter int SEL_W = 8
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             flip_i,
  input  logic             core_wr_i,
  input  logic [1:0]       core_i,
  output logic [SEL_W-1:0] sel_o
);
  always_comb begin
    sel_o = sel_i;
    if (flip_i)    sel_o[0]   = ~sel_i[0];
    if (core_wr_i) sel_o[2:1] = core_i;
  end
endmodule

// File: rtl/clksrc_pp_readback.sv
module clksrc_pp_readback
  import clksrc_pp_pkg::*;
#(
  parameter int SRC_W     = 3,
  parameter int DIV_W     = 4,
  parameter int LVAL_W    = 6,
  parameter bit LOWJIT_OK = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        sel_i,
  input  logic [SRC_W-1:0]  src0_i,
  input  logic [DIV_W-1:0]  div0_i,
  input  logic [SRC_W-1:0]  src1_i,
  input  logic [DIV_W-1:0]  div1_i,
  input  logic [LVAL_W-1:0] lval_i,
  output logic [1:0]        rd_core,
  output logic [SRC_W-1:0]  rd_src,
  output logic [DIV_W-1:0]  rd_div,
  output logic [LVAL_W-1:0] rd_lval,
  output logic              rd_illegal
);
  logic [1:0]        core_d;
  logic [SRC_W-1:0]  src_d;
  logic [DIV_W-1:0]  div_d;
  logic [LVAL_W-1:0] lval_d;
  logic              ill_d;

  always_comb begin
    core_d = sel_i[2:1];
    src_d  = '0;
    div_d  = '0;
    lval_d = '0;
    ill_d  = 1'b0;
    case (core_d)
      CORE_MUX, CORE_LJ: begin
        src_d = sel_i[0] ? src0_i : src1_i;
        div_d = sel_i[0] ? div0_i : div1_i;
        ill_d = (core_d == CORE_LJ) && !LOWJIT_OK;
      end
      CORE_PLL: lval_d = lval_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_core    <= '0;
      rd_src     <= '0;
      rd_div     <= '0;
      rd_lval    <= '0;
      rd_illegal <= 1'b0;
    end else begin
      rd_core    <= core_d;
      rd_src     <= src_d;
      rd_div     <= div_d;
      rd_lval    <= lval_d;
      rd_illegal <= ill_d;
    end
  end

  // R10: the flag only accompanies the low-jitter code
  assert_illegal_code_R10: assert property (@(posedge clk) disable iff (rst)
    rd_illegal |-> (rd_core == CORE_LJ));

  // R8: a PLL decode never presents mux fields
  assert_pll_no_mux_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_core == CORE_PLL) |-> (rd_src == '0 && rd_div == '0));
endmodule

// File: rtl/clksrc_pingpong.sv
module clksrc_pingpong
  import clksrc_pp_pkg::*;
#(
  parameter int FIELD_W  = 4,
  parameter int SRC_W    = 3,
  parameter int DIV_W    = 4,
  parameter int SEL_W    = 8,
  parameter int PLL_W    = 16,
  parameter int LVAL_W   = 6,
  parameter int LVAL_LSB = 3,
  parameter bit LOWJIT_OK = 1'b0,
  parameter logic [4*FIELD_W-1:0] CTL_RST = '0,
  parameter logic [SEL_W-1:0]     SEL_RST = '0,
  parameter logic [PLL_W-1:0]     PLL_RST = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [1:0]           req_core,
  input  logic [SRC_W-1:0]     req_src,
  input  logic [DIV_W-1:0]     req_div,
  input  logic [LVAL_W-1:0]    req_lval,
  output logic                 busy,
  output logic                 done,
  output logic [4*FIELD_W-1:0] ctl_word,
  output logic [SEL_W-1:0]     sel_word,
  output logic [PLL_W-1:0]     pll_word,
  output logic [1:0]           rd_core,
  output logic [SRC_W-1:0]     rd_src,
  output logic [DIV_W-1:0]     rd_div,
  output logic [LVAL_W-1:0]    rd_lval,
  output logic                 rd_illegal
);
  localparam int NBANK  = 2;
  localparam int BANK_W = 2 * FIELD_W;
  localparam int CTL_W  = NBANK * BANK_W;

  seq_t              state_q;
  logic [CTL_W-1:0]  ctl_q, ctl_bank;
  logic [SEL_W-1:0]  sel_q, sel_next;
  logic [PLL_W-1:0]  pll_q, pll_ins;
  logic              done_q;
  logic [1:0]        tgt_core;
  logic [SRC_W-1:0]  tgt_src;
  logic [DIV_W-1:0]  tgt_div;
  logic [LVAL_W-1:0] tgt_lval;

  logic [SRC_W-1:0]  bank_src [NBANK];
  logic [DIV_W-1:0]  bank_div [NBANK];
  logic [BANK_W-1:0] active_byte;

  // Idle bank index is the select bit itself.
  clksrc_pp_bankwr #(
    .FIELD_W(FIELD_W), .SRC_W(SRC_W), .DIV_W(DIV_W), .NBANK(NBANK)
  ) u_bankwr (
    .ctl_i (ctl_q),
    .bank_i(sel_q[0]),
    .src_i (tgt_src),
    .div_i (tgt_div),
    .ctl_o (ctl_bank)
  );

  clksrc_pp_selupd #(.SEL_W(SEL_W)) u_selupd (
    .sel_i    (sel_q),
    .flip_i   (state_q == ST_FLIP),
    .core_wr_i(state_q == ST_CORE),
    .core_i   (tgt_core),
    .sel_o    (sel_next)
  );

  always_comb begin
    pll_ins = pll_q;
    pll_ins[LVAL_LSB +: LVAL_W] = tgt_lval;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_field
    assign bank_src[b] = ctl_q[b*BANK_W + FIELD_W +: SRC_W];
    assign bank_div[b] = ctl_q[b*BANK_W +: DIV_W];
  end

  assign active_byte = sel_q[0] ? ctl_q[BANK_W-1:0] : ctl_q[CTL_W-1:BANK_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      ctl_q    <= CTL_RST;
      sel_q    <= SEL_RST;
      pll_q    <= PLL_RST;
      done_q   <= 1'b0;
      tgt_core <= '0;
      tgt_src  <= '0;
      tgt_div  <= '0;
      tgt_lval <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          tgt_core <= req_core;
          tgt_src  <= req_src;
          tgt_div  <= req_div;
          tgt_lval <= req_lval;
          case (req_core)
            CORE_MUX: state_q <= ST_BANK;
            CORE_PLL: state_q <= ST_PLL;
            default:  state_q <= ST_CORE;
          endcase
        end
        ST_BANK: begin
          ctl_q   <= ctl_bank;
          state_q <= ST_FLIP;
        end
        ST_FLIP: begin
          sel_q   <= sel_next;
          state_q <= ST_CORE;
        end
        ST_PLL: begin
          pll_q   <= pll_ins;
          state_q <= ST_CORE;
        end
        ST_CORE: begin
          sel_q   <= sel_next;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  clksrc_pp_readback #(
    .SRC_W(SRC_W), .DIV_W(DIV_W), .LVAL_W(LVAL_W), .LOWJIT_OK(LOWJIT_OK)
  ) u_readback (
    .clk       (clk),
    .rst       (rst),
    .sel_i     (sel_q[2:0]),
    .src0_i    (bank_src[0]),
    .div0_i    (bank_div[0]),
    .src1_i    (bank_src[1]),
    .div1_i    (bank_div[1]),
    .lval_i    (pll_q[LVAL_LSB +: LVAL_W]),
    .rd_core   (rd_core),
    .rd_src    (rd_src),
    .rd_div    (rd_div),
    .rd_lval   (rd_lval),
    .rd_illegal(rd_illegal)
  );

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign ctl_word = ctl_q;
  assign sel_word = sel_q;
  assign pll_word = pll_q;

  // R2: the live bank is untouched while the idle one is written
  assert_live_bank_kept_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BANK) |=> $stable(active_byte));

  // R3: the select bit inverts right after the bank write
  assert_select_flip_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FLIP) |=> (sel_q[0] != $past(sel_q[0])));

  // R3: completion is a single-cycle pulse
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: core-source write keeps the select bit and upper bits
  assert_core_keep_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CORE) |=> (sel_q[0] == $past(sel_q[0]) &&
                              sel_q[SEL_W-1:3] == $past(sel_q[SEL_W-1:3])));

  // R5: the control word changes only in the bank-write step
  assert_ctl_only_bank_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_BANK) |=> $stable(ctl_q));

  // R6: the PLL word changes only in the PLL step
  assert_pll_only_step_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_PLL) |=> $stable(pll_q));
endmodule

// File: tb/clksrc_pingpong_bench.sv
module clksrc_pingpong_bench;
  localparam logic [15:0] CTL_R = 16'h2531;
  localparam logic [7:0]  SEL_R = 8'hA1;
  localparam logic [15:0] PLL_R = 16'hF0A7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_core = '0;
  logic [2:0]  req_src = '0;
  logic [3:0]  req_div = '0;
  logic [5:0]  req_lval = '0;
  logic        busy, done, rd_illegal;
  logic [15:0] ctl_word, pll_word;
  logic [7:0]  sel_word;
  logic [1:0]  rd_core;
  logic [2:0]  rd_src;
  logic [3:0]  rd_div;
  logic [5:0]  rd_lval;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [15:0] m_ctl = CTL_R;
  logic [7:0]  m_sel = SEL_R;
  logic [15:0] m_pll = PLL_R;

  always #2 clk = ~clk;

  clksrc_pingpong #(
    .LOWJIT_OK(1'b0), .CTL_RST(CTL_R), .SEL_RST(SEL_R), .PLL_RST(PLL_R)
  ) u_clksrc_pingpong (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_core(req_core),
    .req_src(req_src), .req_div(req_div), .req_lval(req_lval),
    .busy(busy), .done(done), .ctl_word(ctl_word), .sel_word(sel_word),
    .pll_word(pll_word), .rd_core(rd_core), .rd_src(rd_src), .rd_div(rd_div),
    .rd_lval(rd_lval), .rd_illegal(rd_illegal)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Reference model of the state after a request.
  task automatic model_apply(input logic [1:0] core, input logic [2:0] s,
                             input logic [3:0] d, input logic [5:0] l);
    if (core == 2'd0) begin
      if (m_sel[0]) m_ctl[15:8] = {1'b0, s, d};
      else          m_ctl[7:0]  = {1'b0, s, d};
      m_sel[0] = ~m_sel[0];
    end
    if (core == 2'd1) m_pll[8:3] = l;
    m_sel[2:1] = core;
  endtask

  task automatic check_all(input string req);
    logic [1:0] c;
    logic [2:0] es;
    logic [3:0] ed;
    logic [5:0] el;
    c = m_sel[2:1];
    es = '0; ed = '0; el = '0;
    if (c == 2'd0 || c == 2'd3) begin
      es = m_sel[0] ? m_ctl[6:4] : m_ctl[14:12];
      ed = m_sel[0] ? m_ctl[3:0] : m_ctl[11:8];
    end else if (c == 2'd1) begin
      el = m_pll[8:3];
    end
    chk(req, "ctl_word", 32'(ctl_word), 32'(m_ctl));
    chk(req, "sel_word", 32'(sel_word), 32'(m_sel));
    chk(req, "pll_word", 32'(pll_word), 32'(m_pll));
    chk(req, "rd_core",  32'(rd_core),  32'(c));
    chk(req, "rd_src",   32'(rd_src),   32'(es));
    chk(req, "rd_div",   32'(rd_div),   32'(ed));
    chk(req, "rd_lval",  32'(rd_lval),  32'(el));
    chk(req, "rd_illegal", 32'(rd_illegal), 32'(c == 2'd3));
    chk(req, "busy idle", 32'(busy), 32'd0);
  endtask

  task automatic issue(input logic [1:0] core, input logic [2:0] s,
                       input logic [3:0] d, input logic [5:0] l);
    req_valid = 1'b1; req_core = core; req_src = s; req_div = d; req_lval = l;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(req, "done seen", 32'(done), 32'd1);
    @(negedge clk);
  endtask

  task automatic run_req(input logic [1:0] core, input logic [2:0] s,
                         input logic [3:0] d, input logic [5:0] l,
                         input string req);
    model_apply(core, s, d, l);
    issue(core, s, d, l);
    wait_done(req);
    check_all(req);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "ctl reset", 32'(ctl_word), 32'(CTL_R));
    chk("R1", "sel reset", 32'(sel_word), 32'(SEL_R));
    chk("R1", "pll reset", 32'(pll_word), 32'(PLL_R));
    chk("R1", "busy reset", 32'(busy), 32'd0);
    chk("R1", "done reset", 32'(done), 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_all("R7");
  endtask

  // Cycle-exact mux path: bank, flip, core, done.
  task automatic t_mux_timing;
    logic [15:0] c0;
    logic [7:0]  s0;
    c0 = m_ctl; s0 = m_sel;
    model_apply(2'd0, 3'd5, 4'd9, 6'd0);
    issue(2'd0, 3'd5, 4'd9, 6'd0);
    chk("R3", "busy after accept", 32'(busy), 32'd1);
    chk("R3", "ctl before E1", 32'(ctl_word), 32'(c0));
    @(negedge clk);
    chk("R2", "idle bank written", 32'(ctl_word), 32'(m_ctl));
    chk("R3", "sel before E2", 32'(sel_word), 32'(s0));
    @(negedge clk);
    chk("R3", "select flipped", 32'(sel_word[0]), 32'(m_sel[0]));
    chk("R3", "core not yet", 32'(sel_word[2:1]), 32'(s0[2:1]));
    chk("R3", "done low at E2", 32'(done), 32'd0);
    @(negedge clk);
    chk("R3", "done at E3", 32'(done), 32'd1);
    chk("R4", "sel after core", 32'(sel_word), 32'(m_sel));
    @(negedge clk);
    chk("R3", "done one cycle", 32'(done), 32'd0);
    check_all("R7");
  endtask

  task automatic t_pll_timing;
    logic [15:0] c0;
    logic [15:0] p0;
    c0 = m_ctl; p0 = m_pll;
    model_apply(2'd1, 3'd6, 4'd3, 6'h2A);
    issue(2'd1, 3'd6, 4'd3, 6'h2A);
    chk("R6", "pll before E1", 32'(pll_word), 32'(p0));
    @(negedge clk);
    chk("R6", "pll at E1", 32'(pll_word), 32'(m_pll));
    chk("R6", "done low at E1", 32'(done), 32'd0);
    @(negedge clk);
    chk("R6", "done at E2", 32'(done), 32'd1);
    chk("R5", "ctl unchanged", 32'(ctl_word), 32'(c0));
    @(negedge clk);
    check_all("R8");
  endtask

  task automatic t_busy_ignore;
    model_apply(2'd0, 3'd1, 4'd2, 6'd0);
    issue(2'd0, 3'd1, 4'd2, 6'd0);
    req_valid = 1'b1; req_core = 2'd2; req_src = 3'd7; req_div = 4'd7;
    @(negedge clk);
    req_valid = 1'b1; req_core = 2'd1; req_lval = 6'h3F;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done("R11");
    check_all("R11");
    repeat (3) @(negedge clk);
    chk("R11", "no queued request", 32'(busy), 32'd0);
    check_all("R11");
  endtask

  initial begin
    t_reset();
    t_mux_timing();
    run_req(2'd0, 3'd7, 4'd0, 6'd0, "R2");
    t_pll_timing();
    run_req(2'd2, 3'd4, 4'd4, 6'h11, "R9");
    run_req(2'd3, 3'd2, 4'd5, 6'h05, "R10");
    run_req(2'd0, 3'd2, 4'hF, 6'd0, "R4");
    run_req(2'd0, 3'd3, 4'h6, 6'd0, "R7");
    t_busy_ignore();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule